// File: doc/BRIEF.md
# Sign-Extending Down-Counter Timer

This block is a down-counting timer register for a processor core. It loses one count on every timebase tick. It raises an interrupt when its value crosses from zero into the negative range, or when software loads it with a value that calls for immediate delivery.

The counter has two widths. In the classic mode it is 32 bits wide, and a read returns the value zero-extended to 64 bits. When the wide-mode input is set, the counter is `WIDE_W` bits wide, and a read returns the value sign-extended to 64 bits. A write keeps only the bits of the active width and treats the top one as the sign.

Interrupt delivery follows one of two styles:
- **Level style:** any negative write fires the interrupt, and a non-negative write withdraws it.
- **Edge style:** a negative write fires the interrupt only when the stored value was non-negative before the write.

Setting the `FIXED_WIDE` parameter pins the counter to the wide width. This turns the same block into a hypervisor-style timer with no mode input.

Top module: `sdec_timer`

## Requirements
- R1: A tick with no write in the same cycle lowers the stored value by exactly one at the active width.
- R2: In narrow mode the counter is 32 bits wide. A read returns bits 31:0 of the counter with bits 63:32 zero. Decrementing 0x80000000 gives 0x7FFFFFFF.
- R3: In wide mode the counter is `WIDE_W` bits wide, with the sign at bit `WIDE_W-1`. A read returns the value sign-extended to 64 bits. A value stored in narrow mode reads back sign-extended from bit 31 once wide mode is selected.
- R4: A write keeps bits n-1:0 of the data, where n is 32 or `WIDE_W`, and sign-extends from bit n-1. All higher data bits are ignored.
- R5: A write whose stored result is 0, 1 or 2 asserts `irq_o` in the next cycle, in either delivery style.
- R6: With `level_mode_i` = 1 (level style), a write whose result is negative asserts `irq_o`.
- R7: With `level_mode_i` = 0 (edge style), a negative write asserts `irq_o` only if bit n-1 of the stored value was 0 before the write. Otherwise `irq_o` keeps its state.
- R8: In level style, a write of a non-negative value of 3 or more deasserts `irq_o`. In edge style, such a write leaves `irq_o` unchanged.
- R9: A tick that takes bit n-1 of the value from 0 to 1 asserts `irq_o`. The interrupt then stays asserted until it is cleared.
- R10: `irq_clr_i` deasserts `irq_o` in the next cycle. If a write or a tick in the same cycle would assert the interrupt, the assertion wins.
- R11: When a write and a tick arrive in the same cycle, the written value is stored and no decrement is applied.
- R12: Reset loads the counter with 0xFFFFFFFF sign-extended from bit 31 and deasserts `irq_o`. A narrow-mode read then returns 0x00000000FFFFFFFF, and the next tick raises no interrupt.
- R13: With `FIXED_WIDE` = 1 the counter always works at `WIDE_W` bits and ignores `wide_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timebase tick; decrement enable |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 64 | Software write data |
| wide_mode_i | input | 1 | 1 selects the `WIDE_W`-bit counter, 0 the 32-bit one |
| level_mode_i | input | 1 | 1 selects level-style delivery, 0 edge-style |
| irq_clr_i | input | 1 | Clears the pending interrupt |
| rd_data_o | output | 64 | Read value, zero- or sign-extended by mode |
| irq_o | output | 1 | Pending timer interrupt |

## Verification
The write path is swept with values chosen at every boundary:
- 0, 1, 2 and 3, which separate the below-three rule from the sign rules;
- 0x7FFFFFFF and 0x80000000, which separate the narrow sign bit from the wide one;
- data whose high bits are set, which exposes truncation errors;
- negative values written straight after negative values, which separate edge style from level style.

Each value is tried in all four combinations of width and delivery style, and the stimulus is driven into a fixed-wide instance at the same time. The ticks that follow each write show the decrement, the 32-bit wrap and the zero-to-minus-one interrupt. Directed sequences then cover:
- a write and a tick in the same cycle;
- a clear in the same cycle as a raise;
- an edge-style positive write that must keep a pending interrupt;
- a mode switch with no write between.

// File: rtl/sdec_pkg.sv
`timescale 1ns/1ps
package sdec_pkg;
  localparam int NARROW_W    = 32;
  localparam int DATA_W      = 64;
  localparam int SMALL_LIMIT = 3;

  typedef enum logic {
    DLV_EDGE  = 1'b0,
    DLV_LEVEL = 1'b1
  } dlv_mode_e;
endpackage

// File: rtl/sdec_fmt.sv
`timescale 1ns/1ps
// Cuts a raw value to the active width and sign-extends it back to WIDE_W.
module sdec_fmt #(
  parameter int WIDE_W = 56
) (
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] raw_i,
  output logic [WIDE_W-1:0] norm_o,
  output logic              sign_o
);
  import sdec_pkg::*;
  localparam int PAD_W = WIDE_W - NARROW_W;

  always_comb begin
    if (wide_i) begin
      norm_o = raw_i;
      sign_o = raw_i[WIDE_W-1];
    end else begin
      norm_o = {{PAD_W{raw_i[NARROW_W-1]}}, raw_i[NARROW_W-1:0]};
      sign_o = raw_i[NARROW_W-1];
    end
  end
endmodule

// File: rtl/sdec_counter.sv
`timescale 1ns/1ps
module sdec_counter #(
  parameter int WIDE_W = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDE_W-1:0] wr_val_i,
  input  logic              tick_i,
  input  logic [WIDE_W-1:0] dec_val_i,
  output logic [WIDE_W-1:0] count_o
);
  logic [WIDE_W-1:0] count_d, count_q;
  logic              count_en;

  // A write beats a tick in the same cycle.
  always_comb begin
    count_d = count_q;
    if (wr_en_i) begin
      count_d = wr_val_i;
    end else if (tick_i) begin
      count_d = dec_val_i;
    end
  end

  assign count_en = wr_en_i | tick_i;

  // Reset value: 0xFFFFFFFF sign-extended from bit 31, i.e. all ones.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '1;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/sdec_irq.sv
`timescale 1ns/1ps
module sdec_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_mode_i,
  input  logic wr_en_i,
  input  logic wr_small_i,
  input  logic wr_neg_i,
  input  logic old_sign_i,
  input  logic tick_uf_i,
  input  logic clr_i,
  output logic irq_o
);
  import sdec_pkg::*;

  dlv_mode_e dlv;
  logic      wr_raise, wr_lower, irq_d, irq_q;

  assign dlv = dlv_mode_e'(level_mode_i);

  always_comb begin
    wr_raise = 1'b0;
    wr_lower = 1'b0;
    if (wr_en_i) begin
      if (wr_small_i) begin
        wr_raise = 1'b1;
      end else if (wr_neg_i) begin
        wr_raise = (dlv == DLV_LEVEL) | ~old_sign_i;
      end else begin
        wr_lower = (dlv == DLV_LEVEL);
      end
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (clr_i | wr_lower) begin
      irq_d = 1'b0;
    end
    if (wr_raise | tick_uf_i) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sdec_timer.sv
`timescale 1ns/1ps
// WIDE_W must lie in 33..64.
module sdec_timer #(
  parameter int WIDE_W     = 56,
  parameter bit FIXED_WIDE = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [63:0] wr_data_i,
  input  logic        wide_mode_i,
  input  logic        level_mode_i,
  input  logic        irq_clr_i,
  output logic [63:0] rd_data_o,
  output logic        irq_o
);
  import sdec_pkg::*;
  localparam int EXT_W = DATA_W - WIDE_W;

  logic [1:0]        rst_pipe;
  logic              rst_n_q;
  logic              eff_wide;
  logic [WIDE_W-1:0] count, wr_norm, dec_raw, dec_norm;
  logic              wr_neg, wr_small, dec_sign, old_sign, tick_uf;
  logic [63:0]       wide_rd;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_q = rst_pipe[1];

  assign eff_wide = wide_mode_i | FIXED_WIDE;

  sdec_fmt #(.WIDE_W(WIDE_W)) u_wr_fmt (
    .wide_i (eff_wide),
    .raw_i  (wr_data_i[WIDE_W-1:0]),
    .norm_o (wr_norm),
    .sign_o (wr_neg)
  );

  assign dec_raw = count - WIDE_W'(1);

  sdec_fmt #(.WIDE_W(WIDE_W)) u_dec_fmt (
    .wide_i (eff_wide),
    .raw_i  (dec_raw),
    .norm_o (dec_norm),
    .sign_o (dec_sign)
  );

  assign old_sign = eff_wide ? count[WIDE_W-1] : count[NARROW_W-1];
  assign wr_small = (wr_norm < WIDE_W'(SMALL_LIMIT));
  assign tick_uf  = tick_i & ~wr_en_i & ~old_sign & dec_sign;

  sdec_counter #(.WIDE_W(WIDE_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_q),
    .wr_en_i   (wr_en_i),
    .wr_val_i  (wr_norm),
    .tick_i    (tick_i),
    .dec_val_i (dec_norm),
    .count_o   (count)
  );

  sdec_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_q),
    .level_mode_i (level_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_small_i   (wr_small),
    .wr_neg_i     (wr_neg),
    .old_sign_i   (old_sign),
    .tick_uf_i    (tick_uf),
    .clr_i        (irq_clr_i),
    .irq_o        (irq_o)
  );

  generate
    if (WIDE_W < DATA_W) begin : g_ext
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:WIDE_W];
      assign wide_rd   = {{EXT_W{count[WIDE_W-1]}}, count};
    end else begin : g_full
      assign wide_rd = count;
    end
  endgenerate

  assign rd_data_o = eff_wide ? wide_rd : {{(DATA_W-NARROW_W){1'b0}}, count[NARROW_W-1:0]};
endmodule

// File: rtl/sdec_timer_chk.sv
`timescale 1ns/1ps
module sdec_timer_chk #(
  parameter bit FIXED_WIDE = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [31:0] wr_lo,
  input logic        wide_mode_i,
  input logic        level_mode_i,
  input logic        irq_clr_i,
  input logic [63:0] rd_data_o,
  input logic        irq_o
);
  logic narrow;
  assign narrow = ~FIXED_WIDE & ~wide_mode_i;

  a_r1_tick_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow && tick_i && !wr_en_i) |=>
      (!narrow || rd_data_o[31:0] == $past(rd_data_o[31:0]) - 32'd1));

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow |-> (rd_data_o[63:32] == 32'd0));

  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow && wr_en_i) |=> (!narrow || rd_data_o[31:0] == $past(wr_lo)));

  a_r5_small_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow && wr_en_i && wr_lo < 32'd3) |=> irq_o);

  a_r6_level_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow && wr_en_i && level_mode_i && wr_lo[31]) |=> irq_o);

  a_r8_level_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow && wr_en_i && level_mode_i && !wr_lo[31] && wr_lo >= 32'd3) |=> !irq_o);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !wr_en_i && !tick_i) |=> !irq_o);
endmodule

bind sdec_timer sdec_timer_chk #(.FIXED_WIDE(FIXED_WIDE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_n_q),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .wr_lo        (wr_data_i[31:0]),
  .wide_mode_i  (wide_mode_i),
  .level_mode_i (level_mode_i),
  .irq_clr_i    (irq_clr_i),
  .rd_data_o    (rd_data_o),
  .irq_o        (irq_o)
);

// File: tb/sdec_timer_tb.sv
`timescale 1ns/1ps
module sdec_timer_tb;
  localparam int WW = 56;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
  logic        wide = 1'b0, level = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd, rd_hv;
  logic        irq, irq_hv;

  int checks = 0;
  int errors = 0;

  logic [63:0] m, mh;
  logic        mirq, mirqh;

  always #10 clk = ~clk;

  sdec_timer #(.WIDE_W(WW), .FIXED_WIDE(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wide_mode_i(wide), .level_mode_i(level),
    .irq_clr_i(irq_clr), .rd_data_o(rd), .irq_o(irq));

  sdec_timer #(.WIDE_W(WW), .FIXED_WIDE(1'b1)) u_hv (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wide_mode_i(1'b0), .level_mode_i(level),
    .irq_clr_i(irq_clr), .rd_data_o(rd_hv), .irq_o(irq_hv));

  function automatic logic [63:0] sx(input logic [63:0] v, input int n);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  function automatic logic [63:0] exp_rd(input logic [63:0] v, input logic w);
    return w ? v : {32'd0, v[31:0]};
  endfunction

  task automatic model(inout logic [63:0] mv, inout logic mi,
                       input logic wr, input logic [63:0] d, input logic tk,
                       input logic clr, input logic w, input logic lv);
    int n;
    logic old_s, raise, lower, uf;
    logic [63:0] nv;
    n = w ? WW : 32;
    old_s = mv[n-1];
    raise = 1'b0; lower = 1'b0; uf = 1'b0;
    if (wr) begin
      nv = sx(d, n);
      raise = (nv < 64'd3) | (lv & nv[63]) | (!lv & nv[63] & !old_s);
      lower = lv & !nv[63] & !raise;
      mv = nv;
    end else if (tk) begin
      nv = sx(mv - 64'd1, n);
      uf = !old_s & nv[63];
      mv = nv;
    end
    if (clr || lower) mi = 1'b0;
    if (raise || uf) mi = 1'b1;
  endtask

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [63:0] d, input logic tk,
                      input logic clr, input string trd, input string tirq);
    wr_en = wr; wr_data = d; tick = tk; irq_clr = clr;
    @(posedge clk); #5;
    model(m, mirq, wr, d, tk, clr, wide, level);
    model(mh, mirqh, wr, d, tk, clr, 1'b1, level);
    wr_en = 1'b0; tick = 1'b0; irq_clr = 1'b0;
    chk64(trd, rd, exp_rd(m, wide));
    chk1(tirq, irq, mirq);
    chk64("R13", rd_hv, mh);
    chk1("R13", irq_hv, mirqh);
  endtask

  logic [63:0] vals [14];

  initial begin
    vals = '{64'd0, 64'd1, 64'd2, 64'd3,
             64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
             64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0001,
             64'h1234_0000_0000_0005, 64'h0080_0000_0000_0000,
             64'hFFFF_FFFF_FFFF_FFFE, 64'h00FF_FFFF_FFFF_FFFF,
             64'h8000_0000_0000_0000, 64'h0000_0000_0000_0004};
    m = 64'hFFFF_FFFF_FFFF_FFFF; mirq = 1'b0;
    mh = 64'hFFFF_FFFF_FFFF_FFFF; mirqh = 1'b0;

    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    // R12: reset state
    chk64("R12", rd, 64'h0000_0000_FFFF_FFFF);
    chk1("R12", irq, 1'b0);
    chk64("R13", rd_hv, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1'b0, '0, 1'b1, 1'b0, "R12/R1", "R12");

    for (int c = 0; c < 4; c++) begin
      wide  = c[1];
      level = c[0];
      for (int i = 0; i < 14; i++) begin
        string ti;
        logic [63:0] nv;
        nv = sx(vals[i], wide ? WW : 32);
        if (nv < 64'd3)   ti = "R5";
        else if (nv[63])  ti = level ? "R6" : "R7";
        else              ti = "R8";
        step(1'b0, '0, 1'b0, 1'b1, "R10", "R10");
        step(1'b1, vals[i], 1'b0, 1'b0, wide ? "R3/R4" : "R2/R4", ti);
        for (int t = 0; t < 4; t++) step(1'b0, '0, 1'b1, 1'b0, "R1", "R9");
      end
    end

    // R3: narrow value reads sign-extended once wide is selected
    wide = 1'b0; level = 1'b1;
    step(1'b1, 64'h0000_0000_8000_0000, 1'b0, 1'b0, "R2", "R6");
    wide = 1'b1;
    step(1'b0, '0, 1'b0, 1'b0, "R3", "R6");
    wide = 1'b0;
    // R8: edge-style positive write keeps a pending irq
    level = 1'b0;
    step(1'b1, 64'd0, 1'b0, 1'b0, "R5", "R5");
    step(1'b1, 64'd5, 1'b0, 1'b0, "R4", "R8");
    level = 1'b1;
    step(1'b1, 64'd5, 1'b0, 1'b0, "R4", "R8");
    // R11: write and tick together
    step(1'b1, 64'd10, 1'b1, 1'b0, "R11", "R11");
    // R10: raise beats clear
    step(1'b1, 64'd0, 1'b0, 1'b1, "R10", "R10");
    step(1'b0, '0, 1'b1, 1'b1, "R9", "R10");
    step(1'b0, '0, 1'b0, 1'b1, "R10", "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule